// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses, at fetch time, whether a conditional branch at a given PC will be taken. It runs two component predictors side by side. The first is a local predictor: a tagless table of 2-bit saturating counters, indexed by the low PC bits. The second is a global predictor, which indexes its own 2-bit counter table with the XOR of the low PC bits and a global history register of recent outcomes. A third table of 2-bit counters, also indexed by the PC, learns which of the two components to trust for each branch. Its verdict picks the final prediction.

The prediction path is combinational from `pred_pc`. Along with the final guess, the block returns both component guesses and the history value it used. The fetch pipeline carries these with the branch. When the branch resolves, the pipeline presents the PC, the real outcome, the carried history and both carried component guesses on the resolve port. In one clock the block then trains every table and shifts the real outcome into the history register.

Top module: `tourn_bpred`

## Requirements
- R1: After reset, every counter in all three tables holds 01 (weakly not-taken) and the history register is zero. Every PC therefore predicts not-taken, and the selector chooses the local component (`pred_use_global` = 0).
- R2: A counter's upper bit is its predicted direction (1 = taken). A taken outcome moves it up by one and a not-taken outcome moves it down by one. It saturates at 00 and at 11.
- R3: A counter at 11 needs two consecutive not-taken outcomes before it predicts not-taken. A counter at 00 likewise needs two consecutive taken outcomes before it predicts taken.
- R4: Each accepted resolve shifts the outcome into bit 0 of the history register (taken = 1), and the older bits move one place up. `pred_hist` shows the register.
- R5: The global component reads the counter at index `pred_pc[GH_W-1:0] XOR history`.
- R6: When exactly one component was correct, the selector counter for `res_pc` moves by one. It moves up (toward global) if the global guess was right and down (toward local) if the local guess was right. Selector upper bit 1 means use the global prediction.
- R7: When both component guesses were right, or both were wrong, the selector counter is unchanged.
- R8: `pred_taken` equals `pred_global` when `pred_use_global` is 1, and `pred_local` otherwise.
- R9: The global table is trained at index `res_pc[GH_W-1:0] XOR res_hist`, using the history carried with the resolve and not the current register value.
- R10: While `res_valid` is 0, no table and no history bit changes, whatever the other resolve inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | PC_W | PC of the branch being fetched |
| pred_taken | output | 1 | Final direction guess |
| pred_use_global | output | 1 | 1 when the selector picked the global component |
| pred_local | output | 1 | Local component guess |
| pred_global | output | 1 | Global component guess |
| pred_hist | output | GH_W | History value used for this guess |
| res_valid | input | 1 | Resolve request present this cycle |
| res_pc | input | PC_W | PC of the resolved branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| res_hist | input | GH_W | History carried from prediction time |
| res_local_pred | input | 1 | Local guess carried from prediction time |
| res_global_pred | input | 1 | Global guess carried from prediction time |

## Verification
The bench builds the block with an 8-bit PC and 3-bit indices for all three tables plus 3 bits of history. With this configuration, the 256 PCs alias onto eight entries per table, and a bench model of 24 counters tracks all the state exactly. The reset sweep therefore covers every PC. A long pseudo-random stream of resolves mixes carried histories that match and that differ from the live register, and both realistic and arbitrary carried component guesses. This stream reaches every selector training case, saturation at both ends, and the aliasing between global indices.

// File: rtl/tourn_pkg.sv
package tourn_pkg;

    // Weakly not-taken: the state every counter takes at reset.
    localparam logic [1:0] CTR_INIT = 2'b01;

    // One saturating step of a 2-bit counter.
    function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic up);
        logic [1:0] nxt;
        if (up) begin
            nxt = (cur == 2'b11) ? cur : cur + 2'd1;
        end else begin
            nxt = (cur == 2'b00) ? cur : cur - 2'd1;
        end
        return nxt;
    endfunction

    // Direction encoded in a counter.
    function automatic logic ctr_dir(input logic [1:0] cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/tourn_ctr_table.sv
module tourn_ctr_table #(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [1:0]       rd_ctr,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_up
);
    import tourn_pkg::*;

    localparam int ENTRIES = 1 << IDX_W;

    typedef struct packed {
        logic [ENTRIES-1:0][1:0] ctr;
    } tbl_state_t;

    tbl_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (upd_en) begin
            state_d.ctr[upd_idx] = ctr_step(state_q.ctr[upd_idx], upd_up);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.ctr <= {ENTRIES{CTR_INIT}};
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_ctr = state_q.ctr[rd_idx];

endmodule

// File: rtl/tourn_hist_reg.sv
module tourn_hist_reg #(
    parameter int GH_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            shift_bit,
    output logic [GH_W-1:0] hist
);
    typedef struct packed {
        logic [GH_W-1:0] bits;
    } hist_state_t;

    hist_state_t state_d, state_q;
    logic [GH_W-1:0] shifted;

    generate
        if (GH_W == 1) begin : g_single
            assign shifted = shift_bit;
        end else begin : g_multi
            assign shifted = {state_q.bits[GH_W-2:0], shift_bit};
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        if (shift_en) begin
            state_d.bits = shifted;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.bits <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign hist = state_q.bits;

endmodule

// File: rtl/tourn_idx_hash.sv
module tourn_idx_hash #(
    parameter int PC_W = 32,
    parameter int GH_W = 10
) (
    input  logic [PC_W-1:0] pc,
    input  logic [GH_W-1:0] hist,
    output logic [GH_W-1:0] idx
);
    assign idx = pc[GH_W-1:0] ^ hist;
endmodule

// File: rtl/tourn_bpred.sv
module tourn_bpred #(
    parameter int PC_W      = 32,
    parameter int LOC_IDX_W = 10,
    parameter int GH_W      = 10,
    parameter int SEL_IDX_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    output logic            pred_use_global,
    output logic            pred_local,
    output logic            pred_global,
    output logic [GH_W-1:0] pred_hist,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic [GH_W-1:0] res_hist,
    input  logic            res_local_pred,
    input  logic            res_global_pred
);
    import tourn_pkg::*;

    logic [GH_W-1:0] hist_q;
    logic [GH_W-1:0] glb_rd_idx, glb_wr_idx;
    logic [1:0]      loc_ctr, glb_ctr, sel_ctr;

    typedef struct packed {
        logic loc_ok;
        logic glb_ok;
        logic sel_en;
        logic sel_up;
    } train_t;

    train_t train_d;

    always_comb begin
        train_d.loc_ok = (res_local_pred == res_taken);
        train_d.glb_ok = (res_global_pred == res_taken);
        train_d.sel_en = res_valid && (train_d.loc_ok != train_d.glb_ok);
        train_d.sel_up = train_d.glb_ok;
    end

    tourn_hist_reg #(.GH_W(GH_W)) u_hist (
        .clk(clk), .rst_n(rst_n),
        .shift_en(res_valid), .shift_bit(res_taken),
        .hist(hist_q)
    );

    tourn_idx_hash #(.PC_W(PC_W), .GH_W(GH_W)) u_hash_rd (
        .pc(pred_pc), .hist(hist_q), .idx(glb_rd_idx)
    );

    tourn_idx_hash #(.PC_W(PC_W), .GH_W(GH_W)) u_hash_wr (
        .pc(res_pc), .hist(res_hist), .idx(glb_wr_idx)
    );

    tourn_ctr_table #(.IDX_W(LOC_IDX_W)) u_local (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(pred_pc[LOC_IDX_W-1:0]), .rd_ctr(loc_ctr),
        .upd_en(res_valid), .upd_idx(res_pc[LOC_IDX_W-1:0]), .upd_up(res_taken)
    );

    tourn_ctr_table #(.IDX_W(GH_W)) u_global (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(glb_rd_idx), .rd_ctr(glb_ctr),
        .upd_en(res_valid), .upd_idx(glb_wr_idx), .upd_up(res_taken)
    );

    tourn_ctr_table #(.IDX_W(SEL_IDX_W)) u_select (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(pred_pc[SEL_IDX_W-1:0]), .rd_ctr(sel_ctr),
        .upd_en(train_d.sel_en), .upd_idx(res_pc[SEL_IDX_W-1:0]), .upd_up(train_d.sel_up)
    );

    assign pred_local      = ctr_dir(loc_ctr);
    assign pred_global     = ctr_dir(glb_ctr);
    assign pred_use_global = ctr_dir(sel_ctr);
    assign pred_taken      = pred_use_global ? pred_global : pred_local;
    assign pred_hist       = hist_q;

endmodule

// File: rtl/tourn_bpred_chk.sv
module tourn_bpred_chk #(
    parameter int PC_W      = 32,
    parameter int LOC_IDX_W = 10,
    parameter int GH_W      = 10,
    parameter int SEL_IDX_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] pred_pc,
    input logic            pred_taken,
    input logic            pred_use_global,
    input logic            pred_local,
    input logic            pred_global,
    input logic [GH_W-1:0] pred_hist,
    input logic            res_valid,
    input logic [PC_W-1:0] res_pc,
    input logic            res_taken,
    input logic [GH_W-1:0] res_hist,
    input logic            res_local_pred,
    input logic            res_global_pred
);
    logic agree_ok;
    assign agree_ok = ((res_local_pred == res_taken) == (res_global_pred == res_taken));

    // R10
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(pred_hist));

    // R4
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> pred_hist == {$past(pred_hist), $past(res_taken)}[GH_W-1:0]);

    // R8
    final_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_local == pred_global) |-> (pred_taken == pred_local));

    // R7
    sel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && agree_ok && res_pc == pred_pc) |=>
            (pred_pc != $past(pred_pc)) || (pred_use_global == $past(pred_use_global)));

    // R2
    local_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_pc == pred_pc && pred_local == res_taken) |=>
            (pred_pc != $past(pred_pc)) || (pred_local == $past(pred_local)));

endmodule

bind tourn_bpred tourn_bpred_chk #(
    .PC_W(PC_W), .LOC_IDX_W(LOC_IDX_W), .GH_W(GH_W), .SEL_IDX_W(SEL_IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_use_global(pred_use_global), .pred_local(pred_local),
    .pred_global(pred_global), .pred_hist(pred_hist), .res_valid(res_valid),
    .res_pc(res_pc), .res_taken(res_taken), .res_hist(res_hist),
    .res_local_pred(res_local_pred), .res_global_pred(res_global_pred)
);

// File: tb/tourn_bpred_bench.sv
module tourn_bpred_bench;
    localparam int PW = 8;
    localparam int IW = 3;
    localparam int NE = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] pred_pc = '0;
    logic          pred_taken, pred_use_global, pred_local, pred_global;
    logic [IW-1:0] pred_hist;
    logic          res_valid = 1'b0;
    logic [PW-1:0] res_pc = '0;
    logic          res_taken = 1'b0;
    logic [IW-1:0] res_hist = '0;
    logic          res_local_pred = 1'b0;
    logic          res_global_pred = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int m_loc [NE];
    int m_glb [NE];
    int m_sel [NE];
    int m_gh;

    always #4 clk = ~clk;

    tourn_bpred #(.PC_W(PW), .LOC_IDX_W(IW), .GH_W(IW), .SEL_IDX_W(IW)) u_tourn_bpred (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_use_global(pred_use_global), .pred_local(pred_local),
        .pred_global(pred_global), .pred_hist(pred_hist), .res_valid(res_valid),
        .res_pc(res_pc), .res_taken(res_taken), .res_hist(res_hist),
        .res_local_pred(res_local_pred), .res_global_pred(res_global_pred)
    );

    function automatic int sat(input int c, input bit up);
        if (up) return (c == 3) ? 3 : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
        end
    endtask

    // Compare every output against the model at the given PC.
    task automatic check_all(input logic [PW-1:0] pc);
        int li, gi, lp, gp, us;
        @(negedge clk);
        pred_pc = pc;
        #1;
        li = pc % NE;
        gi = (pc % NE) ^ m_gh;
        lp = m_loc[li] / 2;
        gp = m_glb[gi] / 2;
        us = m_sel[li] / 2;
        chk("R2 local", pred_local, lp);
        chk("R5 global", pred_global, gp);
        chk("R6 select", pred_use_global, us);
        chk("R8 final", pred_taken, us ? gp : lp);
        chk("R4 hist", pred_hist, m_gh);
    endtask

    task automatic resolve(input logic [PW-1:0] pc, input bit t, input int h,
                           input bit lp, input bit gp);
        @(negedge clk);
        res_valid = 1'b1; res_pc = pc; res_taken = t;
        res_hist = h[IW-1:0]; res_local_pred = lp; res_global_pred = gp;
        @(posedge clk);
        m_loc[pc % NE] = sat(m_loc[pc % NE], t);
        m_glb[(pc % NE) ^ h] = sat(m_glb[(pc % NE) ^ h], t);
        if ((lp == t) != (gp == t)) m_sel[pc % NE] = sat(m_sel[pc % NE], gp == t);
        m_gh = ((m_gh << 1) | int'(t)) % NE;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic local_dir(input logic [PW-1:0] pc, input int exp, input string req);
        @(negedge clk);
        pred_pc = pc;
        #1;
        chk(req, pred_local, exp);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] lf;
        for (int i = 0; i < NE; i++) begin
            m_loc[i] = 1; m_glb[i] = 1; m_sel[i] = 1;
        end
        m_gh = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state seen at every PC
        for (int p = 0; p < 256; p++) begin
            @(negedge clk);
            pred_pc = p[PW-1:0];
            #1;
            chk("R1 taken", pred_taken, 0);
            chk("R1 select", pred_use_global, 0);
            chk("R1 hist", pred_hist, 0);
        end

        // R10: junk on the resolve fields without valid
        @(negedge clk);
        res_pc = 8'h05; res_taken = 1'b1; res_hist = 3'h6;
        res_local_pred = 1'b0; res_global_pred = 1'b1;
        repeat (4) @(posedge clk);
        for (int p = 0; p < NE; p++) check_all(p[PW-1:0]);
        @(negedge clk);
        chk("R10 hist unchanged", pred_hist, 0);

        // R2/R3: saturation and two-miss flip on pc 5
        resolve(8'h05, 1, m_gh, 0, 0);
        local_dir(8'h05, 1, "R2 up step");
        resolve(8'h05, 1, m_gh, 0, 0);
        resolve(8'h05, 1, m_gh, 0, 0);
        resolve(8'h05, 0, m_gh, 0, 0);
        local_dir(8'h05, 1, "R3 one miss keeps taken");
        resolve(8'h05, 0, m_gh, 0, 0);
        local_dir(8'h05, 0, "R3 second miss flips");
        resolve(8'h05, 0, m_gh, 0, 0);
        resolve(8'h05, 0, m_gh, 0, 0);
        resolve(8'h05, 1, m_gh, 0, 0);
        local_dir(8'h05, 0, "R2 floor saturation");
        resolve(8'h05, 1, m_gh, 0, 0);
        local_dir(8'h05, 1, "R3 two taken flip from floor");

        // R4: history pattern 1,0,1 lands as 3'b101
        resolve(8'h11, 1, m_gh, 1, 1);
        resolve(8'h12, 0, m_gh, 0, 0);
        resolve(8'h13, 1, m_gh, 1, 1);
        @(negedge clk);
        #1;
        chk("R4 history 101", pred_hist, 5);

        // R6/R7: selector on pc 2
        resolve(8'h02, 1, m_gh, 0, 1);
        resolve(8'h02, 1, m_gh, 0, 1);
        local_dir(8'h02, m_loc[2] / 2, "R2 pc2 local");
        @(negedge clk); pred_pc = 8'h02; #1;
        chk("R6 toward global", pred_use_global, 1);
        resolve(8'h02, 1, m_gh, 1, 1);
        resolve(8'h02, 0, m_gh, 1, 1);
        @(negedge clk); pred_pc = 8'h02; #1;
        chk("R7 unchanged", pred_use_global, 1);
        resolve(8'h02, 0, m_gh, 0, 1);
        resolve(8'h02, 0, m_gh, 0, 1);
        @(negedge clk); pred_pc = 8'h02; #1;
        chk("R6 toward local", pred_use_global, 0);

        // Sweep: R5, R8, R9 against the model
        lf = 8'hA5;
        for (int i = 0; i < 3000; i++) begin
            bit t, lp, gp;
            int h;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            check_all(lf);
            t = lf[0] ^ lf[3] ^ (i % 5 == 0);
            h = (i % 4 == 0) ? int'(lf[6:4]) : m_gh;   // R9 stale history
            if (i % 3 == 0) begin
                lp = lf[1]; gp = lf[2];
            end else begin
                lp = m_loc[lf % NE] / 2;
                gp = m_glb[(lf % NE) ^ m_gh] / 2;
            end
            resolve(lf, t, h, lp, gp);
        end
        for (int p = 0; p < NE; p++) check_all(p[PW-1:0]);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule